// File: doc/BRIEF.md
# Sized Integer ALU with Per-Operation Flag Policy

This block is a purely combinational integer arithmetic and logic unit. It works on byte, word and long operands. It covers these operations:

- plain and extended add and subtract
- negate, compare, clear and test
- the bitwise AND, OR, XOR and NOT
- logical and arithmetic shifts
- rotates, both with and without the extend bit

A surrounding datapath provides the operands and the current five status flags (extend, negative, zero, overflow, carry). It takes back the result, the next flag values and a write-enable per flag.

Every operation follows its own flag policy. Depending on the operation, a flag is computed from the sized result, forced to a constant, or left as it was. All flag evaluation happens at the selected operand size. Only the sized low part of the result is meaningful, and the bits above it are driven to zero.

A shift or rotate count comes from one of two sources:

- a short immediate field, in which 0 stands for 8
- a register count from 0 to 63

A register count of zero leaves the operand intact.

Top module: `alu_sized`

## Requirements
- R1: Size code 00 selects byte, 01 word, 10 or 11 long. Flag vectors are ordered {X,N,Z,V,C} on bits 4..0. Result bits above the selected size are zero. For every flag whose write-enable is 0, `flg_out` equals `flg_in`.
- R2: For every operation that computes N and Z, N is the sign bit of the sized result and Z is 1 exactly when the sized result is zero.
- R3: ADD computes dst+src, SUB computes dst-src, and NEG computes 0-dst. C is the carry or borrow out of the sized width and V is signed overflow at that width. X is written with the value of C, and all five flags are written.
- R4: ADDX and SUBX use `flg_in` X as carry or borrow in and write all five flags. X equals C. Z is cleared on a nonzero result and keeps its input value on a zero result.
- R5: CMP computes N, Z, V and C exactly like SUB. It never writes X.
- R6: AND, OR, XOR, NOT (of dst) and TST (passes dst) write N and Z from the result, force V=0 and C=0, and do not write X.
- R7: CLR returns zero and forces N=0, Z=1, V=0, C=0. It does not write X.
- R8: When `cnt_imm`=1 the count is `cnt[2:0]`, with 0 meaning 8. When `cnt_imm`=0 the count is `cnt[5:0]`, from 0 to 63.
- R9: LSL, LSR, ASL and ASR set C and X to the last bit shifted out. ASR fills with the sign bit. V is 0, except that for ASL V is 1 when the sign bit changed at any step.
- R10: ROL and ROR rotate within the sized width. C is the last bit rotated out, V is 0, and X is not written.
- R11: ROXL and ROXR rotate through X, as a path of width+1 bits. X and C both take the last bit rotated out, and V is 0.
- R12: For every shift or rotate with a count of zero, the result equals the sized dst, C=0 and V=0, N and Z come from the result, and X is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 5 | Operation code (package enum) |
| sz | input | 2 | Operand size code |
| src | input | 32 | Source operand |
| dst | input | 32 | Destination operand, which is also the shifted operand |
| cnt | input | 6 | Shift or rotate count |
| cnt_imm | input | 1 | 1: count is the 3-bit immediate form |
| flg_in | input | 5 | Current flags {X,N,Z,V,C} |
| res | output | 32 | Sized result, zero above the size |
| flg_out | output | 5 | Next flags {X,N,Z,V,C} |
| flg_we | output | 5 | Per-flag write enable |

## Verification
The hardest situations to reach from the ports are the sign-change overflow of ASL and the zero-count corner of the shifts. Uniform random counts across 0..63 rarely produce a count of zero or a sign change that occurs only midway through the shift. The stimulus therefore biases register counts toward 0, 1 and the width boundaries. It also adds directed vectors where the sign flips late, such as a byte value of 0x20 shifted left by 3. Directed vectors also cover two extended-arithmetic cases: a zero result that must keep an input Z of 1, and one that must keep an input Z of 0.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_ADDX = 5'd2,  OP_SUBX = 5'd3,
    OP_NEG  = 5'd4,  OP_CMP  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_NOT  = 5'd9,  OP_TST  = 5'd10, OP_CLR  = 5'd11,
    OP_LSL  = 5'd12, OP_LSR  = 5'd13, OP_ASL  = 5'd14, OP_ASR  = 5'd15,
    OP_ROL  = 5'd16, OP_ROR  = 5'd17, OP_ROXL = 5'd18, OP_ROXR = 5'd19
  } op_e;

  localparam int FX = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;

  function automatic logic [31:0] size_mask(input logic [1:0] s);
    case (s)
      2'b00:   return 32'h0000_00FF;
      2'b01:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int size_msb(input logic [1:0] s);
    case (s)
      2'b00:   return 7;
      2'b01:   return 15;
      default: return 31;
    endcase
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  input  logic         sub,
  input  logic [1:0]   sz,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int WE = W + 1;

  logic [W-1:0]  msk;
  logic [WE-1:0] raw;
  logic          sa, sb, sr;
  int            m;

  always_comb begin
    msk = size_mask(sz);
    m   = size_msb(sz);
    if (sub)
      raw = {1'b0, opb & msk} - {1'b0, opa & msk} - {{W{1'b0}}, cin};
    else
      raw = {1'b0, opb & msk} + {1'b0, opa & msk} + {{W{1'b0}}, cin};
    sum  = raw[W-1:0] & msk;
    cout = raw[m+1];
    sa   = opa[m];
    sb   = opb[m];
    sr   = sum[m];
    ovf  = sub ? ((sa != sb) && (sr != sb)) : ((sa == sb) && (sr != sb));
  end

  // A sized sum never leaks above the selected width
  always_comb begin
    AST_SUM_SIZED: assert ((sum & ~msk) == '0); // R1
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [1:0]   sz,
  output logic [W-1:0] res
);
  logic [W-1:0] raw;

  always_comb begin
    case (op)
      OP_AND:  raw = opb & opa;
      OP_OR:   raw = opb | opa;
      OP_XOR:  raw = opb ^ opa;
      OP_NOT:  raw = ~opb;
      OP_TST:  raw = opb;
      default: raw = '0;
    endcase
    res = raw & size_mask(sz);
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  op_e           op,
  input  logic [W-1:0]  din,
  input  logic [1:0]    sz,
  input  logic [CW-1:0] amt,
  input  logic          xin,
  output logic [W-1:0]  dout,
  output logic          cout,
  output logic          xout,
  output logic          vout
);
  localparam int STEPS = (1 << CW);

  logic [W-1:0] v;
  logic [W-1:0] msk;
  logic         c, x, b, chg;
  int           m;

  always_comb begin
    msk = size_mask(sz);
    m   = size_msb(sz);
    v   = din & msk;
    c   = 1'b0;
    x   = xin;
    chg = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      if (i < int'(amt)) begin
        case (op)
          OP_LSL, OP_ASL: begin
            b = v[m];
            v = (v << 1) & msk;
            if (v[m] != b) chg = 1'b1;
            c = b; x = b;
          end
          OP_LSR: begin
            b = v[0]; v = v >> 1; c = b; x = b;
          end
          OP_ASR: begin
            b = v[0];
            v = (v >> 1) | ({{(W-1){1'b0}}, v[m]} << m);
            c = b; x = b;
          end
          OP_ROL: begin
            b = v[m]; v = ((v << 1) | {{(W-1){1'b0}}, b}) & msk; c = b;
          end
          OP_ROR: begin
            b = v[0]; v = (v >> 1) | ({{(W-1){1'b0}}, b} << m); c = b;
          end
          OP_ROXL: begin
            b = v[m]; v = ((v << 1) | {{(W-1){1'b0}}, x}) & msk; c = b; x = b;
          end
          OP_ROXR: begin
            b = v[0]; v = (v >> 1) | ({{(W-1){1'b0}}, x} << m); c = b; x = b;
          end
          default: b = 1'b0;
        endcase
      end else begin
        b = 1'b0;
      end
    end
    dout = v;
    cout = c;
    xout = x;
    vout = (op == OP_ASL) ? chg : 1'b0;
  end

  always_comb begin
    if (amt == '0) begin
      AST_ZERO_COUNT_KEEPS: assert (dout == (din & msk) && !cout && xout == xin); // R12
    end
    if (op == OP_ROL || op == OP_ROR) begin
      AST_ROT_KEEPS_X: assert (xout == xin); // R10
    end
  end
endmodule

// File: rtl/alu_sized.sv
module alu_sized
  import alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 6,
  parameter int NF = 5
) (
  input  logic [4:0]    op,
  input  logic [1:0]    sz,
  input  logic [W-1:0]  src,
  input  logic [W-1:0]  dst,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_imm,
  input  logic [NF-1:0] flg_in,
  output logic [W-1:0]  res,
  output logic [NF-1:0] flg_out,
  output logic [NF-1:0] flg_we
);
  localparam int IMM_W = 3;

  op_e           opc;
  logic [W-1:0]  as_a, as_b, as_sum, lg_res, sh_res, msk;
  logic          as_cin, as_sub, as_c, as_v;
  logic          sh_c, sh_x, sh_v;
  logic [CW-1:0] amt;
  logic [NF-1:0] calc;
  logic          zero, sgn;
  int            m;

  assign opc = op_e'(op);

  // count source selection
  always_comb begin
    if (cnt_imm)
      amt = (cnt[IMM_W-1:0] == '0) ? CW'(8) : CW'(cnt[IMM_W-1:0]);
    else
      amt = cnt;
  end

  // operand routing into the adder
  always_comb begin
    as_a   = src;
    as_b   = dst;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (opc)
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_ADDX: as_cin = flg_in[FX];
      OP_SUBX: begin as_sub = 1'b1; as_cin = flg_in[FX]; end
      OP_NEG:  begin as_sub = 1'b1; as_a = dst; as_b = '0; end
      default: ;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .opa(as_a), .opb(as_b), .cin(as_cin), .sub(as_sub), .sz(sz),
    .sum(as_sum), .cout(as_c), .ovf(as_v)
  );

  alu_logic #(.W(W)) u_logic (
    .op(opc), .opa(src), .opb(dst), .sz(sz), .res(lg_res)
  );

  alu_shift #(.W(W), .CW(CW)) u_shift (
    .op(opc), .din(dst), .sz(sz), .amt(amt), .xin(flg_in[FX]),
    .dout(sh_res), .cout(sh_c), .xout(sh_x), .vout(sh_v)
  );

  // result select and flag policy
  always_comb begin
    msk    = size_mask(sz);
    m      = size_msb(sz);
    res    = '0;
    calc   = '0;
    flg_we = '0;
    case (opc)
      OP_ADD, OP_SUB, OP_NEG, OP_ADDX, OP_SUBX, OP_CMP: res = as_sum;
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST:            res = lg_res;
      OP_LSL, OP_LSR, OP_ASL, OP_ASR,
      OP_ROL, OP_ROR, OP_ROXL, OP_ROXR:                 res = sh_res;
      default:                                          res = '0;
    endcase
    zero = ((res & msk) == '0);
    sgn  = res[m];
    case (opc)
      OP_ADD, OP_SUB, OP_NEG: begin
        calc   = {as_c, sgn, zero, as_v, as_c};
        flg_we = '1;
      end
      OP_ADDX, OP_SUBX: begin
        calc   = {as_c, sgn, zero & flg_in[FZ], as_v, as_c};
        flg_we = '1;
      end
      OP_CMP: begin
        calc   = {1'b0, sgn, zero, as_v, as_c};
        flg_we = 5'b01111;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST: begin
        calc   = {1'b0, sgn, zero, 1'b0, 1'b0};
        flg_we = 5'b01111;
      end
      OP_CLR: begin
        calc   = 5'b00100;
        flg_we = 5'b01111;
      end
      OP_LSL, OP_LSR, OP_ASL, OP_ASR, OP_ROXL, OP_ROXR: begin
        calc   = {sh_x, sgn, zero, sh_v, sh_c};
        flg_we = {(amt != '0), 4'b1111};
      end
      OP_ROL, OP_ROR: begin
        calc   = {1'b0, sgn, zero, 1'b0, sh_c};
        flg_we = 5'b01111;
      end
      default: ;
    endcase
    flg_out = (calc & flg_we) | (flg_in & ~flg_we);
  end

  always_comb begin
    AST_RES_SIZED: assert ((res & ~msk) == '0); // R1
    AST_HELD_FLAGS: assert (((flg_out ^ flg_in) & ~flg_we) == '0); // R1
    if (opc == OP_ADD || opc == OP_SUB || opc == OP_NEG) begin
      AST_X_TRACKS_C: assert (flg_out[FX] == flg_out[FC]); // R3
    end
    if (opc == OP_CMP) begin
      AST_CMP_NO_X: assert (!flg_we[FX] && flg_out[FC] == as_c); // R5
    end
    if (opc == OP_CLR) begin
      AST_CLR_FLAGS: assert (flg_out[3:0] == 4'b0100 && res == '0); // R7
    end
    if (opc inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST}) begin
      AST_LOGIC_VC_CLEAR: assert (!flg_out[FV] && !flg_out[FC] && !flg_we[FX]); // R6
    end
    if (cnt_imm) begin
      AST_IMM_RANGE: assert (amt >= CW'(1) && amt <= CW'(8)); // R8
    end
  end
endmodule

// File: tb/sim_alu_sized.sv
`timescale 1ns/1ps
module sim_alu_sized;
  import alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  op;
  logic [1:0]  sz;
  logic [31:0] src, dst, res;
  logic [5:0]  cnt;
  logic        cnt_imm;
  logic [4:0]  flg_in, flg_out, flg_we;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  alu_sized u0 (
    .op(op), .sz(sz), .src(src), .dst(dst), .cnt(cnt), .cnt_imm(cnt_imm),
    .flg_in(flg_in), .res(res), .flg_out(flg_out), .flg_we(flg_we)
  );

  function automatic string tag_of(input op_e o);
    case (o)
      OP_ADD, OP_SUB, OP_NEG:                 return "R3";
      OP_ADDX, OP_SUBX:                       return "R4";
      OP_CMP:                                 return "R5";
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST:  return "R6";
      OP_CLR:                                 return "R7";
      OP_ROL, OP_ROR:                         return "R10";
      OP_ROXL, OP_ROXR:                       return "R11";
      default:                                return "R9";
    endcase
  endfunction

  // independent reference: integer arithmetic for add/sub, bit lists for shifts
  task automatic model(input op_e o, input logic [1:0] s, input logic [31:0] a,
                       input logic [31:0] d, input int n, input logic [4:0] fi,
                       output logic [31:0] r, output logic [4:0] fo,
                       output logic [4:0] we);
    int w = (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
    longint umax = (64'sd1 <<< w) - 1;
    longint smax = (64'sd1 <<< (w-1)) - 1;
    longint smin = -(64'sd1 <<< (w-1));
    longint ua = longint'(a) & umax;
    longint ud = longint'(d) & umax;
    longint sa = (ua > smax) ? ua - umax - 1 : ua;
    longint sd = (ud > smax) ? ud - umax - 1 : ud;
    longint ur, sr;
    logic x = fi[4], c = 1'b0, v = 1'b0, z, nn;
    logic bits[32];
    logic fst, b;
    bit arith = 0, sub = 0;
    longint cin = 0;
    we = 5'b01111;
    r = 0;
    case (o)
      OP_ADD:  arith = 1;
      OP_SUB, OP_CMP: begin arith = 1; sub = 1; end
      OP_ADDX: begin arith = 1; cin = fi[4]; end
      OP_SUBX: begin arith = 1; sub = 1; cin = fi[4]; end
      OP_NEG:  begin arith = 1; sub = 1; ua = ud; sa = sd; ud = 0; sd = 0; end
      default: ;
    endcase
    if (arith) begin
      if (sub) begin ur = ud - ua - cin; sr = sd - sa - cin; c = (ud < ua + cin); end
      else     begin ur = ud + ua + cin; sr = sd + sa + cin; c = (ur > umax); end
      v = (sr > smax) || (sr < smin);
      r = 32'(ur & umax);
      if (o != OP_CMP) begin we = 5'b11111; x = c; end
    end else if (o inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST, OP_CLR}) begin
      case (o)
        OP_AND: r = a & d;
        OP_OR:  r = a | d;
        OP_XOR: r = a ^ d;
        OP_NOT: r = ~d;
        OP_TST: r = d;
        default: r = 0;
      endcase
      r = 32'(longint'(r) & umax);
    end else begin
      for (int i = 0; i < 32; i++) bits[i] = (i < w) ? d[i] : 1'b0;
      fst = bits[w-1];
      for (int k = 0; k < n; k++) begin
        if (o inside {OP_LSL, OP_ASL, OP_ROL, OP_ROXL}) begin
          b = bits[w-1];
          for (int i = w-1; i > 0; i--) bits[i] = bits[i-1];
          bits[0] = (o == OP_ROL) ? b : (o == OP_ROXL) ? x : 1'b0;
          if (o == OP_ASL && bits[w-1] != fst) v = 1'b1;
        end else begin
          b = bits[0];
          for (int i = 0; i < w-1; i++) bits[i] = bits[i+1];
          bits[w-1] = (o == OP_ROR) ? b : (o == OP_ROXR) ? x :
                      (o == OP_ASR) ? bits[w-1] : 1'b0;
        end
        c = b;
        if (o != OP_ROL && o != OP_ROR) x = b;
      end
      for (int i = 0; i < 32; i++) r[i] = (i < w) ? bits[i] : 1'b0;
      if (n != 0 && o != OP_ROL && o != OP_ROR) we = 5'b11111;
    end
    nn = r[w-1];
    z  = (r == 0);
    if (o == OP_ADDX || o == OP_SUBX) z = z & fi[2];
    if (o == OP_CLR) begin nn = 0; z = 1; v = 0; c = 0; end
    fo = {we[4] ? x : fi[4], nn, z, v, c};
  endtask

  task automatic run(input op_e o, input logic [1:0] s, input logic [31:0] a,
                     input logic [31:0] d, input logic [5:0] k, input logic im,
                     input logic [4:0] fi, input string tg);
    logic [31:0] er;
    logic [4:0]  ef, ew;
    int          n;
    @(posedge clk);
    op = o; sz = s; src = a; dst = d; cnt = k; cnt_imm = im; flg_in = fi;
    n = im ? ((k[2:0] == 0) ? 8 : int'(k[2:0])) : int'(k);
    model(o, s, a, d, n, fi, er, ef, ew);
    @(negedge clk);
    n_chk++;
    if (res !== er) begin
      n_err++;
      $display("FAIL %s %s res: actual=%h expected=%h", tg, o.name(), res, er);
    end
    n_chk++;
    if (flg_out !== ef || flg_we !== ew) begin
      n_err++;
      $display("FAIL %s %s flags/we: actual=%b/%b expected=%b/%b",
               tg, o.name(), flg_out, flg_we, ef, ew);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    op_e o;
    logic [5:0] k;
    seed = 32'd20240611;
    void'($urandom(seed));
    rst_n = 1'b0;
    op = '0; sz = '0; src = '0; dst = '0; cnt = '0; cnt_imm = 1'b0; flg_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state vector: all zero inputs, ADD gives Z=1 (R1, R2)
    run(OP_ADD, 2'b00, 0, 0, 0, 0, 5'b00000, "R2");
    // directed corners
    run(OP_ADD,  2'b00, 32'h01, 32'h7F, 0, 0, 5'b00000, "R3");      // byte overflow
    run(OP_ADD,  2'b01, 32'h1, 32'hFFFF, 0, 0, 5'b00000, "R3");     // word carry, zero
    run(OP_SUB,  2'b10, 32'h1, 32'h0, 0, 0, 5'b00000, "R3");        // long borrow
    run(OP_NEG,  2'b00, 0, 32'h80, 0, 0, 5'b00000, "R3");           // neg of min
    run(OP_ADDX, 2'b00, 32'hFF, 32'h00, 0, 0, 5'b10100, "R4");      // zero keeps Z=1
    run(OP_ADDX, 2'b00, 32'hFF, 32'h00, 0, 0, 5'b10000, "R4");      // zero keeps Z=0
    run(OP_SUBX, 2'b01, 32'h0, 32'h0, 0, 0, 5'b10100, "R4");        // borrow in
    run(OP_CMP,  2'b10, 32'h5, 32'h5, 0, 0, 5'b10000, "R5");        // X untouched
    run(OP_TST,  2'b01, 0, 32'hABCD8000, 0, 0, 5'b11111, "R6");
    run(OP_CLR,  2'b10, 0, 32'h12345678, 0, 0, 5'b11011, "R7");
    run(OP_LSL,  2'b00, 0, 32'h81, 6'b000000, 1, 5'b00000, "R8");   // imm 0 -> 8
    run(OP_LSR,  2'b01, 0, 32'h8000, 6'b111001, 1, 5'b00000, "R8"); // imm uses low 3
    run(OP_ASL,  2'b00, 0, 32'h20, 3, 0, 5'b00000, "R9");           // late sign change
    run(OP_ASR,  2'b00, 0, 32'h80, 7, 0, 5'b00000, "R9");
    run(OP_ROL,  2'b01, 0, 32'h8001, 1, 0, 5'b10000, "R10");
    run(OP_ROXL, 2'b00, 0, 32'h80, 1, 0, 5'b10000, "R11");
    run(OP_ROXR, 2'b00, 0, 32'h01, 9, 0, 5'b00000, "R11");          // full cycle
    run(OP_LSL,  2'b10, 0, 32'hDEADBEEF, 0, 0, 5'b11011, "R12");    // zero count
    run(OP_ROXR, 2'b00, 0, 32'h00, 0, 0, 5'b10011, "R12");
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      o = op_e'($urandom_range(0, 19));
      case ($urandom_range(0, 5))
        0: k = 6'd0;
        1: k = 6'd1;
        2: k = 6'($urandom_range(7, 9));
        3: k = 6'($urandom_range(15, 17));
        default: k = 6'($urandom_range(0, 63));
      endcase
      run(o, 2'($urandom_range(0, 3)), $urandom(), $urandom(), k,
          1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)), tag_of(o));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule